// File: doc/BRIEF.md
# Banked Data Memory with Indirect Addressing

This block is the byte-wide data store of a small 8-bit microcontroller. The store is divided into four banks of 128 locations each. An instruction reaches a location in one of two ways. With a direct access, the 7-bit offset from the instruction is combined with two bank-select bits held in the status register. With an indirect access, the instruction names an alias offset, and the block redirects the access to the location held in an 8-bit pointer register. For indirect accesses, the pointer's top bit selects the bank within a pair, and a separate status bit selects which pair of banks the pointer reaches.

The low 32 offsets of every bank are reserved for special function registers. Only three are built here: the alias, the status register and the pointer. The status register and the pointer are mirrored, so every bank reaches the same physical register. Offsets 20h to 6Fh are general purpose RAM that belongs to each bank separately. Offsets 70h to 7Fh map to one shared block whatever bank is selected. The pointer is an ordinary memory-mapped register, so software can step it with the normal read and write paths to walk through consecutive locations.

The CPU side has one combinational read port and one write port that commits on the rising clock edge. Both ports can be used in the same cycle.

Top module: `banked_dmem`

## Requirements
- R1: After a synchronous active-low reset, both the status register (offset 03h) and the pointer (offset 04h) read 00h.
- R2: A direct access to an offset in 20h–6Fh reaches the bank given by status bits 6:5. The same offset in different banks holds independent bytes.
- R3: Offsets 70h–7Fh reach one shared block. A byte written there with any bank selected reads back the same with every bank selected.
- R4: The status register (offset 03h, all 8 bits read/write) and the pointer (offset 04h) are the same physical registers from every bank.
- R5: A read or write at offset 00h is redirected to pointer bits 6:0 in bank {status bit 7, pointer bit 7}. Status bit 7 = 0 selects banks 0/1, and 1 selects banks 2/3.
- R6: A value written to the pointer takes effect on the next access. Stepping the pointer by one after each indirect write fills consecutive locations.
- R7: When pointer bits 6:0 are 00h, an access at offset 00h reads 00h, and a write there changes neither the status register, the pointer, nor any RAM location.
- R8: When a read and a write hit the same location in one cycle, the read returns the old byte. The new byte is visible from the cycle after the clock edge.
- R9: The unbuilt special function offsets (01h, 02h, 05h–1Fh) read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr | input | 7 | Offset of the combinational read |
| rd_data | output | 8 | Byte at the resolved read location |
| wr_en | input | 1 | Write strobe, committed on the clock edge |
| wr_addr | input | 7 | Offset of the write |
| wr_data | input | 8 | Byte to write |

## Verification
The hardest cases to reach are the indirect paths, because they need two earlier register writes to be in place before the access: the pointer and the bank-pair bit. Before each indirect access, the bench writes the status register and the pointer through the normal write port. It then checks the result against bytes that it placed earlier with direct accesses in known banks. The same method is used for the case where the pointer refers to itself. Walking the pointer across the shared block with read-increment-write sequences exercises the mirrored pointer and the redirected write together.

// File: rtl/dmem_pkg.sv
// Package: dmem_pkg
// Shared constants, location kinds and the resolved-location record used
// by the banked data memory. Assumes 8-bit data and a 7-bit in-bank offset.
package dmem_pkg;

    parameter int DATA_W      = 8;
    parameter int OFF_W       = 7;
    parameter int BANK_W      = 2;
    parameter int BANK_SIZE   = 1 << OFF_W;

    // Fixed special function offsets (mirrored in all banks)
    parameter logic [OFF_W-1:0] ALIAS_OFF   = 7'h00;
    parameter logic [OFF_W-1:0] STATUS_OFF  = 7'h03;
    parameter logic [OFF_W-1:0] PTR_OFF     = 7'h04;
    parameter logic [OFF_W-1:0] GP_BASE     = 7'h20;
    parameter logic [OFF_W-1:0] SHARED_BASE = 7'h70;

    // Status bit positions
    parameter int ST_PAIR_BIT = 7;
    parameter int ST_BANK_HI  = 6;
    parameter int ST_BANK_LO  = 5;

    typedef enum logic [2:0] {
        LOC_NONE,
        LOC_STATUS,
        LOC_PTR,
        LOC_BANKED,
        LOC_SHARED
    } loc_kind_e;

    typedef struct packed {
        loc_kind_e           kind;
        logic [BANK_W-1:0]   bank;
        logic [OFF_W-1:0]    off;
    } loc_t;

endpackage

// File: rtl/dmem_addr_resolve.sv
// Module: dmem_addr_resolve
// Turns an instruction offset into a physical location. Offset ALIAS_OFF is
// redirected through the pointer, whose bit 7 and status bit 7 form the
// bank. Otherwise status bits 6:5 form the bank. Assumes one access per use;
// purely combinational.
module dmem_addr_resolve
    import dmem_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [OFF_W-1:0]  raw_off,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] ptr,
    output loc_t              loc
);

    logic [BANK_W-1:0] eff_bank;
    logic [OFF_W-1:0]  eff_off;
    logic              indirect;

    // Pick direct or pointer-based bank and offset
    always_comb begin
        indirect = (raw_off == ALIAS_OFF);
        if (indirect) begin
            eff_bank = {status[ST_PAIR_BIT], ptr[DATA_W-1]};
            eff_off  = ptr[OFF_W-1:0];
        end else begin
            eff_bank = status[ST_BANK_HI:ST_BANK_LO];
            eff_off  = raw_off;
        end
    end

    // Classify the effective offset into a location kind
    always_comb begin
        loc.bank = eff_bank;
        loc.off  = eff_off;
        if (eff_off == ALIAS_OFF) begin
            loc.kind = LOC_NONE;
        end else if (eff_off == STATUS_OFF) begin
            loc.kind = LOC_STATUS;
        end else if (eff_off == PTR_OFF) begin
            loc.kind = LOC_PTR;
        end else if (eff_off >= SHARED_BASE) begin
            loc.kind = LOC_SHARED;
        end else if (eff_off >= GP_BASE) begin
            loc.kind = (int'(eff_bank) < NUM_BANKS) ? LOC_BANKED : LOC_NONE;
        end else begin
            loc.kind = LOC_NONE;
        end
    end

endmodule

// File: rtl/dmem_core_regs.sv
// Module: dmem_core_regs
// Holds the mirrored status and pointer registers. Both clear on a
// synchronous active-low reset; writes commit on the rising edge.
module dmem_core_regs
    import dmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  loc_kind_e         wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] ptr_q
);

    // Status register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (wr_en && wr_kind == LOC_STATUS) begin
            status_q <= wr_data;
        end
    end

    // Pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_en && wr_kind == LOC_PTR) begin
            ptr_q <= wr_data;
        end
    end

endmodule

// File: rtl/dmem_gp_store.sv
// Module: dmem_gp_store
// General purpose storage: one array per bank for the banked window and a
// single shared array for the top window. Read is combinational and write
// is on the rising edge. Contents are not reset. Assumes SHARED_BASE is
// aligned to the shared window size.
module dmem_gp_store
    import dmem_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  loc_t              wr_loc,
    input  logic [DATA_W-1:0] wr_data,
    input  loc_t              rd_loc,
    output logic [DATA_W-1:0] rd_data
);

    localparam int GP_PER_BANK  = int'(SHARED_BASE) - int'(GP_BASE);
    localparam int SHARED_DEPTH = BANK_SIZE - int'(SHARED_BASE);
    localparam int SH_W         = $clog2(SHARED_DEPTH);

    logic [DATA_W-1:0] shared_mem [SHARED_DEPTH];
    logic [DATA_W-1:0] bank_rd    [NUM_BANKS];

    logic [OFF_W-1:0] wr_idx;
    logic [OFF_W-1:0] rd_idx;

    // Offsets relative to the start of the banked window
    always_comb begin
        wr_idx = wr_loc.off - GP_BASE;
        rd_idx = rd_loc.off - GP_BASE;
    end

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [DATA_W-1:0] mem [GP_PER_BANK];

            // Write this bank when the write location targets it
            always_ff @(posedge clk) begin
                if (wr_en && wr_loc.kind == LOC_BANKED && int'(wr_loc.bank) == b) begin
                    mem[wr_idx] <= wr_data;
                end
            end

            // Read this bank at the resolved read offset
            always_comb begin
                bank_rd[b] = mem[rd_idx];
            end
        end
    endgenerate

    // Shared window write
    always_ff @(posedge clk) begin
        if (wr_en && wr_loc.kind == LOC_SHARED) begin
            shared_mem[wr_loc.off[SH_W-1:0]] <= wr_data;
        end
    end

    // Select the read byte by location kind
    always_comb begin
        rd_data = '0;
        if (rd_loc.kind == LOC_SHARED) begin
            rd_data = shared_mem[rd_loc.off[SH_W-1:0]];
        end else if (rd_loc.kind == LOC_BANKED) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (int'(rd_loc.bank) == i) begin
                    rd_data = bank_rd[i];
                end
            end
        end
    end

endmodule

// File: rtl/banked_dmem.sv
// Module: banked_dmem
// Top of the banked data memory. Resolves the read and write offsets
// separately against the current status and pointer, updates the mirrored
// registers or the RAM on the clock edge, and muxes the read byte. Assumes
// the CPU presents at most one write per cycle.
module banked_dmem
    import dmem_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] ram_rd;
    loc_t              rd_loc;
    loc_t              wr_loc;

    dmem_addr_resolve #(.NUM_BANKS(NUM_BANKS)) u_rd_resolve (
        .raw_off (rd_addr),
        .status  (status_q),
        .ptr     (ptr_q),
        .loc     (rd_loc)
    );

    dmem_addr_resolve #(.NUM_BANKS(NUM_BANKS)) u_wr_resolve (
        .raw_off (wr_addr),
        .status  (status_q),
        .ptr     (ptr_q),
        .loc     (wr_loc)
    );

    dmem_core_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_kind  (wr_loc.kind),
        .wr_data  (wr_data),
        .status_q (status_q),
        .ptr_q    (ptr_q)
    );

    dmem_gp_store #(.NUM_BANKS(NUM_BANKS)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_loc  (wr_loc),
        .wr_data (wr_data),
        .rd_loc  (rd_loc),
        .rd_data (ram_rd)
    );

    // Final read mux between mirrored registers and RAM
    always_comb begin
        case (rd_loc.kind)
            LOC_STATUS: rd_data = status_q;
            LOC_PTR:    rd_data = ptr_q;
            LOC_BANKED,
            LOC_SHARED: rd_data = ram_rd;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/banked_dmem_checker.sv
// Module: banked_dmem_checker
// Concurrent checks on the banked data memory, bound to the top module.
module banked_dmem_checker
    import dmem_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [OFF_W-1:0]  wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] ptr_q
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && ptr_q == '0));

    assert_status_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == STATUS_OFF) |=> status_q == $past(wr_data));

    assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == STATUS_OFF) |-> rd_data == status_q);

    assert_ptr_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == PTR_OFF) |-> rd_data == ptr_q);

    assert_ptr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PTR_OFF) |=> ptr_q == $past(wr_data));

    assert_self_alias_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ALIAS_OFF && ptr_q[OFF_W-1:0] == ALIAS_OFF) |-> rd_data == '0);

    assert_self_alias_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ALIAS_OFF && ptr_q[OFF_W-1:0] == ALIAS_OFF)
        |=> ($stable(status_q) && $stable(ptr_q)));

    assert_unbuilt_sfr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr < GP_BASE && rd_addr != ALIAS_OFF && rd_addr != STATUS_OFF
         && rd_addr != PTR_OFF) |-> rd_data == '0);

endmodule

bind banked_dmem banked_dmem_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .status_q (status_q),
    .ptr_q    (ptr_q)
);

// File: tb/banked_dmem_bench.sv
// Directed bench for banked_dmem: one task per scenario, each checking itself.
module banked_dmem_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rd_addr = 7'h00;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = 7'h00;
    logic [7:0] wr_data = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    banked_dmem u_banked_dmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // Status value: pair bit, bank bits, low bits clear
    function automatic logic [7:0] st(input bit pair, input logic [1:0] bank);
        return {pair, bank, 5'b0};
    endfunction

    task automatic t_reset();
        rd_chk("R1 status after reset", 7'h03, 8'h00);
        rd_chk("R1 pointer after reset", 7'h04, 8'h00);
    endtask

    task automatic t_banks();
        for (int b = 0; b < 4; b++) begin
            wr(7'h03, st(1'b0, 2'(b)));
            wr(7'h20, 8'hA0 + 8'(b));
            wr(7'h6F, 8'h50 + 8'(b));
        end
        for (int b = 3; b >= 0; b--) begin
            wr(7'h03, st(1'b0, 2'(b)));
            rd_chk("R2 bank low gp", 7'h20, 8'hA0 + 8'(b));
            rd_chk("R2 bank high gp", 7'h6F, 8'h50 + 8'(b));
        end
    endtask

    task automatic t_shared();
        wr(7'h03, st(1'b0, 2'd0));
        wr(7'h75, 8'h3C);
        wr(7'h03, st(1'b0, 2'd3));
        rd_chk("R3 shared seen from bank3", 7'h75, 8'h3C);
        wr(7'h03, st(1'b1, 2'd2));
        wr(7'h7F, 8'h99);
        wr(7'h03, st(1'b0, 2'd1));
        rd_chk("R3 shared seen from bank1", 7'h7F, 8'h99);
    endtask

    task automatic t_mirror();
        wr(7'h03, 8'h4B);            // bank 2, low bits 0Bh
        wr(7'h04, 8'h33);
        rd_chk("R4 status full byte", 7'h03, 8'h4B);
        wr(7'h03, 8'h27);            // bank 1, low bits 07h
        rd_chk("R4 pointer from other bank", 7'h04, 8'h33);
        rd_chk("R4 status from bank1", 7'h03, 8'h27);
    endtask

    task automatic t_indirect();
        wr(7'h03, st(1'b0, 2'd3));
        wr(7'h04, 8'h20);
        rd_chk("R5 pair0 lower bank", 7'h00, 8'hA0);
        wr(7'h04, 8'hA0);
        rd_chk("R5 pair0 upper bank", 7'h00, 8'hA1);
        wr(7'h03, st(1'b1, 2'd0));
        wr(7'h04, 8'h20);
        rd_chk("R5 pair1 lower bank", 7'h00, 8'hA2);
        wr(7'h04, 8'hA0);
        rd_chk("R5 pair1 upper bank", 7'h00, 8'hA3);
        wr(7'h04, 8'hEF);
        wr(7'h00, 8'h77);
        wr(7'h03, st(1'b0, 2'd3));
        rd_chk("R5 indirect write lands in bank3", 7'h6F, 8'h77);
        wr(7'h03, st(1'b1, 2'd1));
        rd_chk("R5 bank1 untouched", 7'h6F, 8'h51);
    endtask

    task automatic t_step();
        logic [7:0] p;
        int n;
        wr(7'h03, st(1'b0, 2'd0));
        wr(7'h04, 8'h70);
        n = 0;
        do begin
            wr(7'h00, 8'hC0 + 8'(n));
            rd(7'h04, p);
            wr(7'h04, p + 8'h01);
            n++;
        end while (!p[6] || p != 8'h7F);
        check("R6 step count", 8'(n), 8'd16);
        rd_chk("R6 pointer after walk", 7'h04, 8'h80);
        wr(7'h03, st(1'b0, 2'd2));
        rd_chk("R6 first stepped", 7'h70, 8'hC0);
        rd_chk("R6 middle stepped", 7'h78, 8'hC8);
        rd_chk("R6 last stepped", 7'h7F, 8'hCF);
    endtask

    task automatic t_self();
        wr(7'h03, st(1'b0, 2'd0));
        wr(7'h04, 8'h00);
        rd_chk("R7 self alias read", 7'h00, 8'h00);
        wr(7'h00, 8'h5A);
        rd_chk("R7 pointer unchanged", 7'h04, 8'h00);
        rd_chk("R7 status unchanged", 7'h03, st(1'b0, 2'd0));
        wr(7'h04, 8'h80);
        wr(7'h00, 8'hE1);
        rd_chk("R7 upper self alias read", 7'h00, 8'h00);
        rd_chk("R7 pointer unchanged upper", 7'h04, 8'h80);
        rd_chk("R7 ram unchanged", 7'h20, 8'hA0);
    endtask

    task automatic t_same_cycle();
        wr(7'h03, st(1'b0, 2'd1));
        wr(7'h30, 8'hEE);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h30; wr_data = 8'h11; rd_addr = 7'h30;
        #1 check("R8 old byte same cycle", rd_data, 8'hEE);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R8 new byte next cycle", rd_data, 8'h11);
    endtask

    task automatic t_unbuilt();
        wr(7'h10, 8'hFF);
        rd_chk("R9 unbuilt 10h", 7'h10, 8'h00);
        wr(7'h01, 8'h12);
        rd_chk("R9 unbuilt 01h", 7'h01, 8'h00);
        rd_chk("R9 status untouched", 7'h03, st(1'b0, 2'd1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_banks();
        t_shared();
        t_mirror();
        t_indirect();
        t_step();
        t_self();
        t_same_cycle();
        t_unbuilt();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule